// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block carries the byte stream of a serial receiver into memory buffers that are listed in a ring of buffer descriptors. It holds an index to the descriptor in use, opens that descriptor's buffer on the first byte that arrives, and packs bytes into 32-bit little-endian words that leave on a simple memory write port. A buffer is closed when its byte limit is reached, when a byte carries end-of-frame, or when a byte carries an error. On close the block reports the descriptor index, byte count and frame/error flags on a status write-back port, pulses an interrupt request and moves to the next descriptor. It returns to the programmed base index after a descriptor whose wrap bit is set.

The descriptor table lives outside the block. The block presents the descriptor index on `bd_idx` and reads back that descriptor's empty bit, wrap bit and buffer address combinationally in the same cycle. The byte limit is legalised and latched only when a buffer opens, so a change to the limit register applies from the next descriptor. Every memory write carries a 4-bit access code taken from a configuration input, with one reserved value replaced.

Top module: `rx_ring_dma`

## Requirements
- R1: While `rst_n` is low at a clock edge, `bd_idx` loads `cfg_base` and `mem_we`, `wb_valid`, `irq` and `busy` go low.
- R2: An accepted byte with buffer position p goes to byte lane p mod 4, at bits [8*lane+7:8*lane] of `mem_data`. A word is written in the cycle after the byte that fills lane 3, or after the byte that closes the buffer. `mem_addr` is the buffer address plus 4*(p div 4). `mem_be` has bits 0 up to the last filled lane set, and lanes above it read as zero.
- R3: A buffer never holds more bytes than its latched limit. The byte that brings the count to the limit closes the buffer, with `wb_count` equal to the limit and `wb_last` and `wb_err` low.
- R4: A byte with `in_eof` high closes the buffer early. The write-back reports the bytes stored, including that byte, with `wb_last` high.
- R5: A byte with `in_err` high closes the buffer, with `wb_err` high and `wb_last` copying `in_eof`.
- R6: The write-back reports the descriptor index that was in use. In the same cycle `bd_idx` becomes that index plus one (modulo the ring size), or `cfg_base` if the closed descriptor had its wrap bit set.
- R7: The limit is sampled when a buffer opens. Changes to `cfg_maxlen` while a buffer is open affect only later buffers.
- R8: Limit legalisation. In framed mode (`cfg_framed`=1) the two low bits of `cfg_maxlen` are cleared, and a result of zero becomes 4. In byte mode a zero limit becomes 1.
- R9: `mem_fc` equals `cfg_fc`, except that 4'b0111 is replaced by 4'b1000.
- R10: A byte that arrives with no buffer open, while the current descriptor's empty bit is low, is dropped. `busy` pulses for one cycle, no write or write-back follows, and `bd_idx` is unchanged.
- R11: A pulse on `ptr_wr` loads `ptr_wdata` into `bd_idx` only while `rx_en` is low and no buffer is open. At any other time it is ignored.
- R12: `irq` pulses for exactly the cycles in which `wb_valid` is high.
- R13: Bytes presented while `rx_en` is low are ignored and do not advance the buffer position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| in_valid | input | 1 | Byte present on in_byte |
| in_byte | input | 8 | Received byte |
| in_eof | input | 1 | This byte ends the frame |
| in_err | input | 1 | This byte was received with an error |
| cfg_maxlen | input | LEN_W | Buffer byte limit, before legalisation |
| cfg_framed | input | 1 | Framed mode (limit in 4-byte multiples) |
| cfg_base | input | IDX_W | First descriptor index of the ring |
| cfg_fc | input | 4 | Access code for memory writes |
| ptr_wr | input | 1 | Software write of descriptor index |
| ptr_wdata | input | IDX_W | Value for the software index write |
| bd_idx | output | IDX_W | Descriptor index in use |
| bd_empty | input | 1 | Indexed descriptor is ready for data |
| bd_wrap | input | 1 | Indexed descriptor is the last in the ring |
| bd_addr | input | ADDR_W | Buffer address of indexed descriptor |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_data | output | 32 | Word data, little-endian lanes |
| mem_be | output | 4 | Byte-lane enables |
| mem_fc | output | 4 | Access code |
| wb_valid | output | 1 | Descriptor status write-back strobe |
| wb_idx | output | IDX_W | Descriptor being closed |
| wb_count | output | LEN_W | Bytes stored in the buffer |
| wb_last | output | 1 | Buffer ends a frame |
| wb_err | output | 1 | Buffer closed on error |
| irq | output | 1 | Buffer-closed interrupt pulse |
| busy | output | 1 | Byte dropped, descriptor not ready |

## Verification
Several close triggers can land on the same byte. A byte can fill the buffer to its limit while also carrying end-of-frame or an error, and that same close may also hit the wrap descriptor, so the index returns to base in the cycle of a partial-word flush. Random stimulus with frequent end-of-frame and error flags and limits from 0 to 12 makes these coincide often. Directed frames also place end-of-frame on exactly the limit byte. Each cycle the bench compares the write word, write-back flags, count and new index against its own model, which gives end-of-frame and error precedence in the reported flags while still reporting the limit-sized count.

// File: rtl/rxr_pkg.sv
// Shared constants and helpers for the receive descriptor ring controller.
package rxr_pkg;
    localparam int unsigned WORD_LANES = 4;
    localparam logic [3:0] FC_FORBIDDEN = 4'b0111;
    localparam logic [3:0] FC_DMA_DEFAULT = 4'b1000;

    typedef enum logic [1:0] {
        CLOSE_NONE,
        CLOSE_FULL,
        CLOSE_FRAME,
        CLOSE_FAULT
    } close_e;

    // Replace the reserved access code by the DMA default.
    function automatic logic [3:0] fc_sanitise(input logic [3:0] raw);
        return (raw == FC_FORBIDDEN) ? FC_DMA_DEFAULT : raw;
    endfunction
endpackage

// File: rtl/rxr_limit.sv
// Legalises the programmed buffer byte limit.
// Framed mode rounds down to a multiple of 4 (minimum 4); byte mode
// raises zero to 1. Purely combinational; assumes LEN_W >= 3.
module rxr_limit #(
    parameter int unsigned LEN_W = 16
) (
    input  logic [LEN_W-1:0] raw,
    input  logic             framed,
    output logic [LEN_W-1:0] lim
);
    logic [LEN_W-1:0] rounded;

    // Round, then replace an illegal zero by the smallest legal limit.
    always_comb begin
        rounded = framed ? {raw[LEN_W-1:2], 2'b00} : raw;
        if (rounded == '0) begin
            lim = framed ? LEN_W'(4) : LEN_W'(1);
        end else begin
            lim = rounded;
        end
    end
endmodule

// File: rtl/rxr_packer.sv
// Gathers received bytes into one memory word, lane 0 first.
// Assumes lanes are filled in ascending order and that the word is
// emitted (and cleared) after lane LANES-1 or on buffer close.
module rxr_packer import rxr_pkg::*; #(
    parameter int unsigned LANES = WORD_LANES,
    localparam int unsigned LANE_W = $clog2(LANES),
    localparam int unsigned DW = 8 * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              emit,
    input  logic [LANE_W-1:0] lane,
    input  logic [7:0]        din,
    output logic [DW-1:0]     merged,
    output logic [LANES-1:0]  be
);
    logic [DW-1:0] hold_q;

    // Insert the incoming byte into its lane of the partial word.
    always_comb begin
        merged = hold_q;
        merged[lane*8 +: 8] = din;
    end

    // Enable every lane from 0 up to the lane just written.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign be[k] = (int'(lane) >= k);
    end

    // Keep the partial word; clear it once it has been written out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (take) begin
            hold_q <= emit ? '0 : merged;
        end
    end
endmodule

// File: rtl/rxr_ring_ptr.sv
// Descriptor index register of the ring.
// Loads the base on reset, steps or wraps on buffer close, and accepts a
// software load when the caller has qualified it. Close wins over load.
module rxr_ring_ptr #(
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] base,
    input  logic             advance,
    input  logic             wrap,
    input  logic             sw_load,
    input  logic [IDX_W-1:0] sw_val,
    output logic [IDX_W-1:0] idx
);
    // Update the index on reset, close or qualified software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= base;
        end else if (advance) begin
            idx <= wrap ? base : idx + IDX_W'(1);
        end else if (sw_load) begin
            idx <= sw_val;
        end
    end
endmodule

// File: rtl/rx_ring_dma.sv
// Receive descriptor ring controller.
// Accepts one byte per cycle, opens the current descriptor's buffer on
// the first byte (reading descriptor fields combinationally), writes
// packed words and a status write-back one cycle after the byte, and
// advances around the ring. Assumes buffer addresses are word aligned
// and ADDR_W >= LEN_W.
module rx_ring_dma import rxr_pkg::*; #(
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned LEN_W  = 16,
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              in_eof,
    input  logic              in_err,
    input  logic [LEN_W-1:0]  cfg_maxlen,
    input  logic              cfg_framed,
    input  logic [IDX_W-1:0]  cfg_base,
    input  logic [3:0]        cfg_fc,
    input  logic              ptr_wr,
    input  logic [IDX_W-1:0]  ptr_wdata,
    output logic [IDX_W-1:0]  bd_idx,
    input  logic              bd_empty,
    input  logic              bd_wrap,
    input  logic [ADDR_W-1:0] bd_addr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_data,
    output logic [3:0]        mem_be,
    output logic [3:0]        mem_fc,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [LEN_W-1:0]  wb_count,
    output logic              wb_last,
    output logic              wb_err,
    output logic              irq,
    output logic              busy
);
    localparam int unsigned LANES  = WORD_LANES;
    localparam int unsigned LANE_W = $clog2(LANES);
    localparam int unsigned DW     = 8 * LANES;

    logic              open_q;
    logic [LEN_W-1:0]  max_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] buf_q;
    logic              wrap_q;

    logic [LEN_W-1:0]  lim_w;
    logic              byte_in;
    logic              take;
    logic              stall;
    logic [LEN_W-1:0]  pos;
    logic [LEN_W-1:0]  nxt_cnt;
    logic [LEN_W-1:0]  eff_max;
    logic [ADDR_W-1:0] eff_buf;
    logic              eff_wrap;
    logic [LANE_W-1:0] lane;
    close_e            reason;
    logic              closing;
    logic              emit;
    logic [ADDR_W-1:0] word_addr;
    logic [DW-1:0]     merged;
    logic [LANES-1:0]  be_w;

    rxr_limit #(.LEN_W(LEN_W)) u_limit (
        .raw    (cfg_maxlen),
        .framed (cfg_framed),
        .lim    (lim_w)
    );

    // Per-byte decode: open-or-continue, position, limit and close reason.
    always_comb begin
        byte_in  = rx_en & in_valid;
        take     = byte_in & (open_q | bd_empty);
        stall    = byte_in & ~open_q & ~bd_empty;
        pos      = open_q ? cnt_q  : '0;
        eff_max  = open_q ? max_q  : lim_w;
        eff_buf  = open_q ? buf_q  : bd_addr;
        eff_wrap = open_q ? wrap_q : bd_wrap;
        nxt_cnt  = pos + LEN_W'(1);
        lane     = pos[LANE_W-1:0];
        if (in_err)                 reason = CLOSE_FAULT;
        else if (in_eof)            reason = CLOSE_FRAME;
        else if (nxt_cnt == eff_max) reason = CLOSE_FULL;
        else                        reason = CLOSE_NONE;
        closing   = take & (reason != CLOSE_NONE);
        emit      = take & ((lane == {LANE_W{1'b1}}) | closing);
        word_addr = eff_buf + ADDR_W'({pos[LEN_W-1:LANE_W], {LANE_W{1'b0}}});
    end

    rxr_packer #(.LANES(LANES)) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .emit   (emit),
        .lane   (lane),
        .din    (in_byte),
        .merged (merged),
        .be     (be_w)
    );

    rxr_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .base    (cfg_base),
        .advance (closing),
        .wrap    (eff_wrap),
        .sw_load (ptr_wr & ~rx_en & ~open_q),
        .sw_val  (ptr_wdata),
        .idx     (bd_idx)
    );

    // Open buffer context: latch limit, address and wrap when a buffer opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            max_q  <= '0;
            cnt_q  <= '0;
            buf_q  <= '0;
            wrap_q <= 1'b0;
        end else if (take) begin
            if (!open_q) begin
                max_q  <= lim_w;
                buf_q  <= bd_addr;
                wrap_q <= bd_wrap;
            end
            cnt_q  <= nxt_cnt;
            open_q <= ~closing;
        end
    end

    // Memory write port: one registered word per emit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
            mem_be   <= '0;
            mem_fc   <= FC_DMA_DEFAULT;
        end else begin
            mem_we <= emit;
            mem_fc <= fc_sanitise(cfg_fc);
            if (emit) begin
                mem_addr <= word_addr;
                mem_data <= merged;
                mem_be   <= be_w;
            end
        end
    end

    // Status write-back, interrupt and busy pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_idx   <= '0;
            wb_count <= '0;
            wb_last  <= 1'b0;
            wb_err   <= 1'b0;
            irq      <= 1'b0;
            busy     <= 1'b0;
        end else begin
            wb_valid <= closing;
            irq      <= closing;
            busy     <= stall;
            if (closing) begin
                wb_idx   <= bd_idx;
                wb_count <= nxt_cnt;
                wb_last  <= in_eof;
                wb_err   <= (reason == CLOSE_FAULT);
            end
        end
    end
endmodule

// File: rtl/rx_ring_dma_chk.sv
// Property checker for rx_ring_dma, attached by bind below.
// Keeps a running byte total from the write strobes to cross-check the
// reported count.
module rx_ring_dma_chk #(
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned LEN_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_en,
    input logic             in_valid,
    input logic             ptr_wr,
    input logic [IDX_W-1:0] bd_idx,
    input logic             mem_we,
    input logic [3:0]       mem_be,
    input logic [3:0]       mem_fc,
    input logic             wb_valid,
    input logic [IDX_W-1:0] wb_idx,
    input logic [LEN_W-1:0] wb_count,
    input logic             irq,
    input logic             busy
);
    logic [LEN_W-1:0] acc_q;
    logic [LEN_W-1:0] this_bytes;

    assign this_bytes = mem_we ? LEN_W'($countones(mem_be)) : '0;

    // Bytes written since the last close.
    always_ff @(posedge clk) begin
        if (!rst_n)        acc_q <= '0;
        else if (wb_valid) acc_q <= '0;
        else               acc_q <= acc_q + this_bytes;
    end

    p_lanes_contiguous_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_be == 4'b0001 || mem_be == 4'b0011 ||
                    mem_be == 4'b0111 || mem_be == 4'b1111));

    p_count_matches_writes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (acc_q + this_bytes == wb_count) && (wb_count != '0));

    p_wb_reports_current_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_idx == $past(bd_idx));

    p_fc_never_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_fc != 4'b0111);

    p_busy_no_output_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_we && !wb_valid);

    p_ptr_write_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wr && rx_en && !in_valid) |=> $stable(bd_idx));

    p_irq_with_wb_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> wb_valid);
endmodule

bind rx_ring_dma rx_ring_dma_chk #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .in_valid (in_valid),
    .ptr_wr   (ptr_wr),
    .bd_idx   (bd_idx),
    .mem_we   (mem_we),
    .mem_be   (mem_be),
    .mem_fc   (mem_fc),
    .wb_valid (wb_valid),
    .wb_idx   (wb_idx),
    .wb_count (wb_count),
    .irq      (irq),
    .busy     (busy)
);

// File: tb/sim_rx_ring_dma.sv
`timescale 1ns/1ps
module sim_rx_ring_dma;
    localparam int IDX_W = 3;
    localparam int LEN_W = 16;
    localparam int ADDR_W = 32;
    localparam int NBD = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0, in_valid = 1'b0, in_eof = 1'b0, in_err = 1'b0;
    logic [7:0] in_byte = '0;
    logic [LEN_W-1:0] cfg_maxlen = 16'd8;
    logic cfg_framed = 1'b0;
    logic [IDX_W-1:0] cfg_base = 3'd2;
    logic [3:0] cfg_fc = 4'b1000;
    logic ptr_wr = 1'b0;
    logic [IDX_W-1:0] ptr_wdata = '0;
    logic [IDX_W-1:0] bd_idx;
    logic bd_empty, bd_wrap;
    logic [ADDR_W-1:0] bd_addr;
    logic mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0] mem_data;
    logic [3:0] mem_be, mem_fc;
    logic wb_valid, wb_last, wb_err, irq, busy;
    logic [IDX_W-1:0] wb_idx;
    logic [LEN_W-1:0] wb_count;

    // descriptor table model (owned by the bench as software)
    logic bd_used [NBD];
    logic bd_wrapm [NBD];
    logic [ADDR_W-1:0] bd_addrm [NBD];

    assign bd_empty = ~bd_used[bd_idx];
    assign bd_wrap  = bd_wrapm[bd_idx];
    assign bd_addr  = bd_addrm[bd_idx];

    always #4 clk = ~clk;

    rx_ring_dma #(.IDX_W(IDX_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid),
        .in_byte(in_byte), .in_eof(in_eof), .in_err(in_err),
        .cfg_maxlen(cfg_maxlen), .cfg_framed(cfg_framed), .cfg_base(cfg_base),
        .cfg_fc(cfg_fc), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
        .bd_idx(bd_idx), .bd_empty(bd_empty), .bd_wrap(bd_wrap), .bd_addr(bd_addr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
        .mem_fc(mem_fc), .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_count(wb_count),
        .wb_last(wb_last), .wb_err(wb_err), .irq(irq), .busy(busy)
    );

    int total = 0;
    int bad = 0;
    string ctx = "reset";

    // reference model state
    logic m_open = 1'b0;
    logic [LEN_W-1:0] m_max = '0, m_cnt = '0;
    logic [ADDR_W-1:0] m_addr = '0;
    logic m_wrap = 1'b0;
    logic [IDX_W-1:0] m_ptr = '0;
    logic [31:0] m_word = '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s (%s): actual=%0h expected=%0h", tag, ctx, act, exp);
        end
    endtask

    function automatic logic [LEN_W-1:0] legal(input logic [LEN_W-1:0] raw, input logic fr);
        logic [LEN_W-1:0] r;
        r = fr ? {raw[LEN_W-1:2], 2'b00} : raw;
        if (r == '0) r = fr ? LEN_W'(4) : LEN_W'(1);
        return r;
    endfunction

    function automatic logic [3:0] exp_fc(input logic [3:0] f);
        return (f == 4'b0111) ? 4'b1000 : f;
    endfunction

    // One cycle: drive at a falling edge, predict, check at the next falling edge.
    task automatic step(input logic v, input logic [7:0] b, input logic eof, input logic err);
        logic e_we, e_wb, e_busy, e_last, e_err, close;
        logic [ADDR_W-1:0] e_addr;
        logic [31:0] e_data;
        logic [3:0] e_be;
        logic [LEN_W-1:0] e_cnt;
        logic [IDX_W-1:0] e_wbidx;
        logic [1:0] lane;
        int mark;
        string wtag;
        e_we = 0; e_wb = 0; e_busy = 0; e_last = 0; e_err = 0; close = 0;
        e_addr = '0; e_data = '0; e_be = '0; e_cnt = '0; e_wbidx = '0; mark = -1;
        wtag = "R3";
        in_valid = v; in_byte = b; in_eof = eof; in_err = err;
        if (v && rx_en) begin
            if (!m_open && bd_used[m_ptr]) begin
                e_busy = 1;
            end else begin
                if (!m_open) begin
                    m_open = 1; m_max = legal(cfg_maxlen, cfg_framed);
                    m_addr = bd_addrm[m_ptr]; m_wrap = bd_wrapm[m_ptr];
                    m_cnt = '0; m_word = '0;
                end
                lane = m_cnt[1:0];
                m_word[lane*8 +: 8] = b;
                close = eof || err || (m_cnt + 1 == m_max);
                if (lane == 2'd3 || close) begin
                    e_we = 1; e_addr = m_addr + {m_cnt[LEN_W-1:2], 2'b00};
                    e_data = m_word;
                    e_be = (lane == 0) ? 4'b0001 : (lane == 1) ? 4'b0011 :
                           (lane == 2) ? 4'b0111 : 4'b1111;
                    m_word = '0;
                end
                m_cnt = m_cnt + 1;
                if (close) begin
                    e_wb = 1; e_cnt = m_cnt; e_last = eof; e_err = err; e_wbidx = m_ptr;
                    wtag = err ? "R5" : eof ? "R4" : "R3";
                    mark = int'(m_ptr);
                    m_ptr = m_wrap ? cfg_base : m_ptr + 1;
                    m_open = 0;
                end
            end
        end else if (ptr_wr && !rx_en && !m_open) begin
            m_ptr = ptr_wdata;
        end
        @(negedge clk);
        chk("R2 write strobe", 64'(mem_we), 64'(e_we));
        if (e_we) begin
            chk("R2 address", 64'(mem_addr), 64'(e_addr));
            chk("R2 data", 64'(mem_data), 64'(e_data));
            chk("R2 lanes", 64'(mem_be), 64'(e_be));
        end
        chk({wtag, " write-back"}, 64'(wb_valid), 64'(e_wb));
        if (e_wb) begin
            chk({wtag, " count"}, 64'(wb_count), 64'(e_cnt));
            chk("R4 last flag", 64'(wb_last), 64'(e_last));
            chk("R5 error flag", 64'(wb_err), 64'(e_err));
            chk("R6 closed index", 64'(wb_idx), 64'(e_wbidx));
        end
        chk("R12 irq", 64'(irq), 64'(e_wb));
        chk("R10 busy", 64'(busy), 64'(e_busy));
        chk("R6 index", 64'(bd_idx), 64'(m_ptr));
        chk("R9 access code", 64'(mem_fc), 64'(exp_fc(cfg_fc)));
        if (mark >= 0) bd_used[mark] = 1'b1;
        in_valid = 0; in_eof = 0; in_err = 0; ptr_wr = 0;
    endtask

    task automatic frame(input int n, input logic eof_last);
        for (int i = 0; i < n; i++)
            step(1'b1, 8'(8'h30 + i), eof_last && (i == n - 1), 1'b0);
    endtask

    task automatic rearm();
        for (int k = 0; k < NBD; k++) bd_used[k] = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog (%s): actual=hung expected=finished", ctx);
        summary();
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        for (int k = 0; k < NBD; k++) begin
            bd_used[k] = 1'b0;
            bd_wrapm[k] = (k == NBD - 1);
            bd_addrm[k] = 32'h1000 * (k + 1);
        end
        // R1: reset loads base and quiets outputs
        repeat (3) @(negedge clk);
        ctx = "R1";
        chk("R1 index at reset", 64'(bd_idx), 64'(cfg_base));
        chk("R1 write idle", 64'(mem_we), 64'd0);
        chk("R1 wb idle", 64'(wb_valid), 64'd0);
        chk("R1 irq idle", 64'(irq), 64'd0);
        chk("R1 busy idle", 64'(busy), 64'd0);
        rst_n = 1'b1;
        m_ptr = cfg_base;
        rx_en = 1'b1;

        ctx = "R3 limit close";   // 10 bytes over limit 8
        frame(10, 1'b1);
        ctx = "R4 short frame";
        frame(3, 1'b1);
        ctx = "R4 eof on limit byte";
        frame(8, 1'b1);
        ctx = "R5 error";
        frame(4, 1'b0);
        step(1'b1, 8'hEE, 1'b0, 1'b1);
        step(1'b1, 8'hE1, 1'b1, 1'b1);

        ctx = "R7 deferred limit";
        frame(2, 1'b0);
        cfg_maxlen = 16'd4;
        frame(8, 1'b0);

        ctx = "R8 byte mode zero";
        cfg_maxlen = 16'd0;
        frame(3, 1'b0);
        ctx = "R8 framed rounding";
        cfg_framed = 1'b1; cfg_maxlen = 16'd6;
        frame(5, 1'b0);
        ctx = "R8 framed zero";
        cfg_maxlen = 16'd2;
        frame(5, 1'b0);
        cfg_framed = 1'b0; cfg_maxlen = 16'd8;

        ctx = "R9 reserved code";
        cfg_fc = 4'b0111;
        frame(4, 1'b1);
        cfg_fc = 4'b1010;
        frame(2, 1'b1);

        ctx = "R10 not ready";
        for (int k = 0; k < NBD; k++) bd_used[k] = 1'b1;
        step(1'b1, 8'h55, 1'b0, 1'b0);
        step(1'b1, 8'h56, 1'b1, 1'b0);
        rearm();
        frame(2, 1'b1);

        ctx = "R11 pointer write";
        rx_en = 1'b0;
        step(1'b0, 8'h0, 1'b0, 1'b0);
        ptr_wr = 1'b1; ptr_wdata = 3'd5;
        step(1'b0, 8'h0, 1'b0, 1'b0);
        rx_en = 1'b1;
        ptr_wr = 1'b1; ptr_wdata = 3'd1;
        step(1'b0, 8'h0, 1'b0, 1'b0);
        frame(2, 1'b0);
        rx_en = 1'b0;
        ptr_wr = 1'b1; ptr_wdata = 3'd0;   // ignored: buffer open
        step(1'b0, 8'h0, 1'b0, 1'b0);

        ctx = "R13 disabled bytes";
        step(1'b1, 8'hAA, 1'b1, 1'b0);
        step(1'b1, 8'hAB, 1'b0, 1'b1);
        rx_en = 1'b1;
        step(1'b1, 8'h77, 1'b1, 1'b0);

        ctx = "R6 wrap to new base";
        rearm();
        cfg_base = 3'd3;
        for (int j = 0; j < NBD; j++) frame(1 + j % 3, 1'b1);

        ctx = "random";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 49) == 0) cfg_maxlen = 16'($urandom_range(0, 12));
            if ($urandom_range(0, 199) == 0) cfg_framed = ~cfg_framed;
            if ($urandom_range(0, 99) == 0) cfg_fc = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 299) == 0) cfg_base = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 29) == 0) rearm();
            if ($urandom_range(0, 149) == 0) rx_en = ~rx_en;
            if ($urandom_range(0, 3) == 0) begin
                ptr_wr = 1'b1; ptr_wdata = 3'($urandom_range(0, 7));
            end
            step($urandom_range(0, 3) != 0, 8'($urandom), $urandom_range(0, 9) == 0,
                 $urandom_range(0, 39) == 0);
        end
        summary();
    end
endmodule